// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches up to 32 external interrupt lines and turns each of them into a CPU interrupt output. Each line has its own sense mode: active-low level, active-high level, falling edge, rising edge or either edge. A condition that is seen is held in a per-line detect bit until software clears it. The line's output goes high when the detect bit is set and the line is enabled.

Software uses a small synchronous register bus with an address, a write strobe, write data and combinational read data. The enable mask has one address that sets bits and another that clears them, so no read-modify-write is needed.

The usual service sequence is:
- read the detect status,
- write ones back to clear the bits it has handled,
- set or clear enables as needed.

Edges are found inside the block clock domain. Each input passes through a two-flop synchronizer, and each new synchronized sample is compared with the previous one.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: Bit n of every mask register and of `irq_out` belongs to line n (`LINES` at most 32). Reset clears the enable mask, the detect bits, all sense codes and the synchronizer and previous-sample flops.
- R2: A write to 0x08 sets each enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to 0x04 clears each enable bit whose write-data bit is 1. Reads of 0x04 and of 0x08 both return the enable mask.
- R4: A read of 0x00 returns detect AND enable, and `irq_out[n]` equals that bit for every line.
- R5: A read of 0x100 returns the detect bits. Writing 1 to a bit there clears it, and writing 0 has no effect.
- R6: Line n's sense code is at 0x180 + 4*n. Only write-data bits 5:0 are stored, and the upper bits read as 0. Any other address reads 0, and a write to it changes nothing.
- R7: Code 0x01 (level low) or 0x02 (level high) sets the detect bit on every clock while the synchronized input is at its active level.
- R8: Code 0x08 (rising), 0x04 (falling) or 0x0C (either edge) sets the detect bit on a matching change between two consecutive synchronized samples. The bit then holds until it is cleared.
- R9: An input change that stays stable becomes visible in the detect bit after the third rising clock edge, and not after the second.
- R10: A sense code outside {0x01, 0x02, 0x04, 0x08, 0x0C}, including 0, never sets the detect bit.
- R11: When a clear write and a new detection hit the same detect bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | LINES | External interrupt lines, asynchronous |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_out | output | LINES | Per-line CPU interrupt outputs |

## Verification
Directed cases cover the following patterns:
- a held level, with a clear written while the level is still active, which shows that detection wins over the clear and that the clear works once the level is gone;
- single pulses on rising, falling and either-edge lines, which show latching and reject edges of the wrong direction;
- an invalid code, which must stay silent;
- a sample taken on the second and on the third edge after an input change, which pins the synchronizer delay exactly.

A seeded random phase then toggles the lines sparsely while mixing enable, clear, sense-code and unmapped writes. This separates enable gating, clear masking and per-mode sense behaviour from each other.

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [LINES-1:0]  irq_out
);
  localparam logic [ADDR_W-1:0] A_REQ  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(12'h100);
  localparam int                CFG_BASE = 'h180;

  logic [LINES-1:0] s1_q, s2_q, prev_q, en_q, det_q, hit, rise, fall, clr_vec;
  logic [5:0]       cfg_q [LINES];
  logic             unused_wdata;

  function automatic logic [ADDR_W-1:0] cfg_addr(input int n);
    return ADDR_W'(CFG_BASE + 4 * n);
  endfunction

  assign rise    = s2_q & ~prev_q;
  assign fall    = ~s2_q & prev_q;
  assign clr_vec = (bus_we && bus_addr == A_DET) ? bus_wdata[LINES-1:0] : '0;
  assign irq_out = det_q & en_q;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    for (int n = 0; n < LINES; n++) begin
      case (cfg_q[n])
        6'h01:   hit[n] = ~s2_q[n];
        6'h02:   hit[n] = s2_q[n];
        6'h04:   hit[n] = fall[n];
        6'h08:   hit[n] = rise[n];
        6'h0C:   hit[n] = rise[n] | fall[n];
        default: hit[n] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      en_q   <= '0;
      det_q  <= '0;
      for (int n = 0; n < LINES; n++) cfg_q[n] <= '0;
    end else begin
      s1_q   <= irq_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      det_q  <= (det_q & ~clr_vec) | hit;
      if (bus_we && bus_addr == A_SET) en_q <= en_q | bus_wdata[LINES-1:0];
      if (bus_we && bus_addr == A_CLR) en_q <= en_q & ~bus_wdata[LINES-1:0];
      for (int n = 0; n < LINES; n++)
        if (bus_we && bus_addr == cfg_addr(n)) cfg_q[n] <= bus_wdata[5:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_REQ) bus_rdata[LINES-1:0] = det_q & en_q;
    if (bus_addr == A_CLR || bus_addr == A_SET) bus_rdata[LINES-1:0] = en_q;
    if (bus_addr == A_DET) bus_rdata[LINES-1:0] = det_q;
    for (int n = 0; n < LINES; n++)
      if (bus_addr == cfg_addr(n)) bus_rdata[5:0] = cfg_q[n];
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET) |=> ((en_q & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));

  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR) |=> ((en_q & $past(bus_wdata[LINES-1:0])) == '0));

  assert_req_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_REQ) |-> (bus_rdata[LINES-1:0] == irq_out));

  assert_det_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(det_q) & ~$past(clr_vec) & ~det_q) == '0));

  assert_det_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(det_q) & det_q & ~$past(hit)) == '0));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_vec & hit) & ~det_q) == '0));
endmodule

// File: tb/ext_irq_sense_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_sense_ctrl_tb_top;
  localparam int LINES = 32;
  logic        clk = 0, rst_n = 0;
  logic [31:0] irq_in = '0;
  logic [8:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata, irq_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_sense_ctrl #(.LINES(LINES), .ADDR_W(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  // reference model built from the requirements
  logic [31:0] m_s1, m_s2, m_prev, m_en, m_det;
  logic [5:0]  m_cfg [LINES];

  function automatic bit sense(input logic [5:0] code, input bit cur, input bit old);
    case (code)
      6'h01: return !cur;
      6'h02: return cur;
      6'h04: return old && !cur;
      6'h08: return cur && !old;
      6'h0C: return cur != old;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_en <= 0; m_det <= 0;
      for (int n = 0; n < LINES; n++) m_cfg[n] <= 0;
    end else begin
      logic [31:0] h, c;
      h = 0;
      for (int n = 0; n < LINES; n++) h[n] = sense(m_cfg[n], m_s2[n], m_prev[n]);
      c = (bus_we && bus_addr == 9'h100) ? bus_wdata : 32'h0;
      m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
      m_det <= (m_det & ~c) | h;
      if (bus_we && bus_addr == 9'h008) m_en <= m_en | bus_wdata;
      if (bus_we && bus_addr == 9'h004) m_en <= m_en & ~bus_wdata;
      for (int n = 0; n < LINES; n++)
        if (bus_we && bus_addr == 9'(384 + 4 * n)) m_cfg[n] <= bus_wdata[5:0];
    end
  end

  function automatic logic [31:0] exp_read(input logic [8:0] a);
    if (a == 9'h000) return m_det & m_en;
    if (a == 9'h004 || a == 9'h008) return m_en;
    if (a == 9'h100) return m_det;
    for (int n = 0; n < LINES; n++) if (a == 9'(384 + 4 * n)) return {26'h0, m_cfg[n]};
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] v);
    bus_we = 0; bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [31:0] rand_code();
    case ($urandom % 8)
      0: return 32'h01; 1: return 32'h02; 2: return 32'h04; 3: return 32'h08;
      4: return 32'h0C; 5: return 32'h00; 6: return 32'hFFFFFF03;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    chk("R1 irq_out after reset", irq_out, 0);
    peek(9'h004, v); chk("R1 enable after reset", v, 0);
    peek(9'h100, v); chk("R1 detect after reset", v, 0);
    peek(9'h180, v); chk("R1 cfg after reset", v, 0);
    // R2 / R3 enable set and clear
    wr(9'h008, 32'hF0); peek(9'h004, v); chk("R2 set", v, 32'hF0);
    wr(9'h008, 32'h03); peek(9'h004, v); chk("R2 zeros keep", v, 32'hF3);
    wr(9'h004, 32'h30); peek(9'h004, v); chk("R3 clear", v, 32'hC3);
    peek(9'h008, v); chk("R3 read via set addr", v, 32'hC3);
    // R6 config storage and unmapped addresses
    wr(9'h184, 32'hFFFFFF02); peek(9'h184, v); chk("R6 cfg low bits", v, 32'h02);
    wr(9'h00C, 32'hFFFFFFFF); peek(9'h00C, v); chk("R6 unmapped read", v, 0);
    peek(9'h004, v); chk("R6 unmapped write ignored", v, 32'hC3);
    wr(9'h000, 32'hFFFFFFFF); peek(9'h100, v); chk("R6 write to 0x00 ignored", v, 0);
    // R7 / R9 level high on line 1
    @(negedge clk); irq_in[1] = 1;
    idle(2); peek(9'h100, v); chk("R9 not after second edge", v[1], 0);
    idle(1); peek(9'h100, v); chk("R9 after third edge", v[1], 1);
    chk("R4 irq_out line1", irq_out[1], 1);
    peek(9'h000, v); chk("R4 request read", v, 32'h2);
    wr(9'h100, 32'h2); peek(9'h100, v); chk("R11 set wins over clear", v[1], 1);
    wr(9'h100, 32'h0); peek(9'h100, v); chk("R5 zero write no effect", v[1], 1);
    @(negedge clk); irq_in[1] = 0; idle(4);
    wr(9'h100, 32'h2); peek(9'h100, v); chk("R5 clear after level gone", v[1], 0);
    chk("R7 level high inactive stays clear", irq_out[1], 0);
    // R8 rising on line 2 (not enabled)
    wr(9'h188, 32'h08);
    @(negedge clk); irq_in[2] = 1; @(negedge clk); irq_in[2] = 0; idle(4);
    peek(9'h100, v); chk("R8 rising pulse latched", v[2], 1);
    chk("R4 disabled line no output", irq_out[2], 0);
    peek(9'h000, v); chk("R4 request masked", v[2], 0);
    idle(4); peek(9'h100, v); chk("R8 edge stays latched", v[2], 1);
    wr(9'h100, 32'h4); peek(9'h100, v); chk("R5 clear edge", v[2], 0);
    // R8 falling on line 3
    wr(9'h18C, 32'h04);
    @(negedge clk); irq_in[3] = 1; idle(4);
    peek(9'h100, v); chk("R8 falling ignores rise", v[3], 0);
    @(negedge clk); irq_in[3] = 0; idle(4);
    peek(9'h100, v); chk("R8 falling detected", v[3], 1);
    wr(9'h100, 32'h8);
    // R10 invalid code on line 4
    wr(9'h190, 32'h03);
    @(negedge clk); irq_in[4] = 1; idle(4); irq_in[4] = 0; idle(4);
    peek(9'h100, v); chk("R10 invalid code silent", v[4], 0);
    // R8 both edges on line 5
    wr(9'h194, 32'h0C);
    @(negedge clk); irq_in[5] = 1; idle(4);
    peek(9'h100, v); chk("R8 both rise", v[5], 1);
    wr(9'h100, 32'h20); peek(9'h100, v); chk("R5 clear both", v[5], 0);
    @(negedge clk); irq_in[5] = 0; idle(4);
    peek(9'h100, v); chk("R8 both fall", v[5], 1);
    wr(9'h100, 32'h20);
    // R7 level low on line 6
    wr(9'h198, 32'h01); idle(2);
    peek(9'h100, v); chk("R7 level low active", v[6], 1);
    @(negedge clk); irq_in[6] = 1; idle(4);
    wr(9'h100, 32'h40); peek(9'h100, v); chk("R7 level low released", v[6], 0);
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R4 R9 irq_out vs model", irq_out, m_det & m_en);
      irq_in = irq_in ^ ($urandom & $urandom & $urandom);
      bus_we = $urandom % 2;
      case ($urandom % 8)
        0: begin bus_addr = 9'h008; bus_wdata = $urandom; end
        1: begin bus_addr = 9'h004; bus_wdata = $urandom; end
        2: begin bus_addr = 9'h100; bus_wdata = $urandom; end
        3, 4: begin bus_addr = 9'(384 + 4 * ($urandom % 32)); bus_wdata = rand_code(); end
        5: begin bus_addr = 9'h000; bus_wdata = $urandom; end
        6: begin bus_addr = 9'h00C; bus_wdata = $urandom; end
        default: begin bus_addr = 9'h100; bus_we = 0; end
      endcase
      #1 chk("R6 R5 read vs model", bus_rdata, exp_read(bus_addr));
    end
    @(negedge clk); bus_we = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule